// File: doc/BRIEF.md
# Triplicated Shift-Chain Upset Monitor

This block is a test structure for measuring how often flip-flops are upset by radiation. A maximal-length linear feedback shift register produces a new byte on every enabled clock. The same byte goes into three identical shift chains, each `DEPTH` stages deep and `W` bits wide. A fourth chain of the same shape carries the same stream and serves as a golden reference. At the far end, a bitwise two-of-three majority vote forms the corrected output. Each copy is compared with the vote. A copy that disagrees is flagged for that cycle, and its own saturating counter is incremented.

When the vote itself differs from the reference chain, two copies were upset in the same bit. A sticky flag records this uncorrectable case. The chain stages have no reset. For this reason, every flag and counter stays idle until `DEPTH` enabled clocks after reset have flushed the chains. A low enable freezes the whole block.

Top module: `upset_monitor`

## Requirements
- R1: The pattern register starts at 0x01 and steps as next = {p[6:0], p[7]^p[5]^p[4]^p[3]} on every enabled edge. After E enabled edges since reset, with E > DEPTH, `vote_o` equals the pattern value pushed on enabled edge E-DEPTH.
- R2: An upset that corrupts only one copy in a given bit leaves `vote_o` equal to the uncorrupted pattern.
- R3: Bit c of `mism_o` is 1 after exactly those enabled edges on which copy c's chain output differed from the vote. It returns to 0 on the next enabled edge without a disagreement.
- R4: The counter of copy c sits at `cnt_o` bits [16c+15:16c]. It increases by exactly one on each enabled edge that sets `mism_o[c]`, and it is otherwise unchanged.
- R5: Each counter saturates at 0xFFFF and stays there while further disagreements occur.
- R6: During the first DEPTH enabled edges after reset, `vote_o`, `mism_o`, `uncorr_o` and all counters stay 0. This holds even when the chains still hold stale, disagreeing data from before the reset.
- R7: When two copies are upset in the same bit, `vote_o` carries the wrong value. `uncorr_o` sets and remains 1 until reset, and the remaining copy is the one flagged and counted.
- R8: While `en_i` is 0, no output changes.
- R9: An active-low reset clears `vote_o`, `mism_o`, `uncorr_o` and all counters, and returns the pattern register to 0x01.
- R10: Upsets in two copies in different bits flag and count both copies. `vote_o` stays correct and `uncorr_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advances pattern, chains and monitor when high |
| vote_o | output | W | Registered two-of-three majority of the copy outputs |
| mism_o | output | 3 | Per-copy disagreement flags, bit c for copy c |
| uncorr_o | output | 1 | Sticky flag: vote differs from the reference chain |
| cnt_o | output | 3*CNT_W | Per-copy saturating upset counters, copy c at bits [c*CNT_W +: CNT_W] |

## Verification
The events this block exists to count are upsets inside the chains, and no stimulus at the ports can produce one. The bench therefore overrides a zero-valued corruption mask at the head of a chosen copy for a single enabled edge. The flipped byte then travels the full chain depth like a genuine stored upset and reaches the comparators DEPTH edges later.

The hardest case to reach is the arming window. A stale disagreement must exist in the chains right after reset, which requires seeding a same-bit double upset just before reset and then watching the flush.

Saturation is reached by holding one copy's mask for more than 65535 enabled edges.

// File: rtl/upset_pkg.sv
package upset_pkg;

    // Number of redundant copies; the voter is a fixed two-of-three.
    localparam int NCOPY = 3;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/upset_lfsr.sv
module upset_lfsr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    output logic [W-1:0] pat_o
);

    typedef struct packed {
        logic [W-1:0] pat;
    } lfsr_t;

    lfsr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.pat = {st_q.pat[W-2:0], ^(st_q.pat & TAPS)};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pat <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign pat_o = st_q.pat;

endmodule

// File: rtl/upset_chain.sv
module upset_chain #(
    parameter int W     = 8,
    parameter int DEPTH = 40
) (
    input  logic         clk_i,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] tail_o
);

    // Stage 0 is the head, stage DEPTH-1 feeds the comparators.
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } chain_t;

    chain_t st_d, st_q;

    // Corruption point at the head; zero in operation, overridden only by a bench.
    logic [W-1:0] upset_mask;
    assign upset_mask = '0;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.stg[0] = din_i ^ upset_mask;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.stg[i] = st_q.stg[i-1];
            end
        end
    end

    // Deliberately no reset: the monitor arms only after a full flush.
    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign tail_o = st_q.stg[DEPTH-1];

endmodule

// File: rtl/upset_judge.sv
module upset_judge
    import upset_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 40,
    parameter int CNT_W = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         en_i,
    input  logic [NCOPY-1:0][W-1:0]      tail_i,
    input  logic [W-1:0]                 ref_i,
    output logic [W-1:0]                 vote_o,
    output logic [NCOPY-1:0]             mism_o,
    output logic                         uncorr_o,
    output logic [NCOPY*CNT_W-1:0]       cnt_o
);

    localparam int                 FILL_W   = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0]  FILL_END = FILL_W'(DEPTH);
    localparam logic [CNT_W-1:0]   CNT_MAX  = '1;

    typedef struct packed {
        logic [FILL_W-1:0]              fill;
        logic [W-1:0]                   vote;
        logic [NCOPY-1:0]               mism;
        logic                           uncorr;
        logic [NCOPY-1:0][CNT_W-1:0]    cnt;
    } judge_t;

    judge_t       st_d, st_q;
    logic [W-1:0] voted;
    logic         armed;

    always_comb begin
        st_d  = st_q;
        armed = (st_q.fill == FILL_END);
        for (int b = 0; b < W; b++) begin
            voted[b] = maj3(tail_i[0][b], tail_i[1][b], tail_i[2][b]);
        end
        if (en_i) begin
            if (!armed) begin
                st_d.fill = st_q.fill + 1'b1;
            end
            st_d.vote   = armed ? voted : '0;
            st_d.uncorr = st_q.uncorr | (armed && (voted != ref_i));
            for (int c = 0; c < NCOPY; c++) begin
                st_d.mism[c] = armed && (tail_i[c] != voted);
                if (st_d.mism[c] && (st_q.cnt[c] != CNT_MAX)) begin
                    st_d.cnt[c] = st_q.cnt[c] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vote_o   = st_q.vote;
    assign mism_o   = st_q.mism;
    assign uncorr_o = st_q.uncorr;
    assign cnt_o    = st_q.cnt;

endmodule

// File: rtl/upset_monitor.sv
module upset_monitor
    import upset_pkg::*;
#(
    parameter int           W     = 8,
    parameter int           DEPTH = 40,
    parameter int           CNT_W = 16,
    parameter logic [W-1:0] TAPS  = 8'hB8,
    parameter logic [W-1:0] SEED  = 8'h01
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   en_i,
    output logic [W-1:0]           vote_o,
    output logic [NCOPY-1:0]       mism_o,
    output logic                   uncorr_o,
    output logic [NCOPY*CNT_W-1:0] cnt_o
);

    logic [W-1:0]            pat;
    logic [NCOPY-1:0][W-1:0] copy_tail;
    logic [W-1:0]            ref_tail;

    upset_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .pat_o  (pat)
    );

    for (genvar c = 0; c < NCOPY; c++) begin : gen_copy
        upset_chain #(.W(W), .DEPTH(DEPTH)) u_chain (
            .clk_i  (clk_i),
            .en_i   (en_i),
            .din_i  (pat),
            .tail_o (copy_tail[c])
        );
    end

    upset_chain #(.W(W), .DEPTH(DEPTH)) u_ref (
        .clk_i  (clk_i),
        .en_i   (en_i),
        .din_i  (pat),
        .tail_o (ref_tail)
    );

    upset_judge #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_judge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .tail_i   (copy_tail),
        .ref_i    (ref_tail),
        .vote_o   (vote_o),
        .mism_o   (mism_o),
        .uncorr_o (uncorr_o),
        .cnt_o    (cnt_o)
    );

endmodule

// File: rtl/upset_monitor_chk.sv
module upset_monitor_chk
    import upset_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 40,
    parameter int CNT_W = 16
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   en_i,
    input logic [W-1:0]           vote_o,
    input logic [NCOPY-1:0]       mism_o,
    input logic                   uncorr_o,
    input logic [NCOPY*CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Independent count of enabled edges since reset, saturating at DEPTH.
    int fill_c;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fill_c <= 0;
        end else if (en_i && fill_c < DEPTH) begin
            fill_c <= fill_c + 1;
        end
    end

    AST_QUIET_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && fill_c < DEPTH) |=> (mism_o == '0 && !uncorr_o && vote_o == '0 && cnt_o == '0)); // R6

    AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(vote_o) && $stable(mism_o) && $stable(uncorr_o) && $stable(cnt_o))); // R8

    AST_UNCORR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uncorr_o |=> uncorr_o); // R7

    for (genvar c = 0; c < NCOPY; c++) begin : gen_cc
        AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(en_i) && mism_o[c] && $past(cnt_o[c*CNT_W +: CNT_W]) != CNT_MAX)
            |-> cnt_o[c*CNT_W +: CNT_W] == CNT_W'($past(cnt_o[c*CNT_W +: CNT_W]) + 1'b1)); // R4

        AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !mism_o[c] |-> $stable(cnt_o[c*CNT_W +: CNT_W])); // R4

        AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(cnt_o[c*CNT_W +: CNT_W]) == CNT_MAX) |-> (cnt_o[c*CNT_W +: CNT_W] == CNT_MAX)); // R5
    end

endmodule

bind upset_monitor upset_monitor_chk #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .vote_o   (vote_o),
    .mism_o   (mism_o),
    .uncorr_o (uncorr_o),
    .cnt_o    (cnt_o)
);

// File: tb/sim_upset_monitor.sv
module sim_upset_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int DEPTH      = 40;
    localparam int CNT_W      = 16;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             en_i = 1'b0;
    logic [W-1:0]     vote_o;
    logic [2:0]       mism_o;
    logic             uncorr_o;
    logic [3*CNT_W-1:0] cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    int ne       = 0;          // enabled edges since reset
    int exp_cnt [3];

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    upset_monitor u0 (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .vote_o   (vote_o),
        .mism_o   (mism_o),
        .uncorr_o (uncorr_o),
        .cnt_o    (cnt_o)
    );

    function automatic logic [7:0] pat(input int n);
        logic [7:0] p = 8'h01;
        for (int i = 0; i < n; i++) p = {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
        return p;
    endfunction

    function automatic logic [7:0] exp_vote();
        return (ne <= DEPTH) ? 8'h00 : pat(ne - 1 - DEPTH);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic chk_cnts(input string req);
        for (int c = 0; c < 3; c++) chk(req, 64'(cnt_o[c*CNT_W +: CNT_W]), 64'(exp_cnt[c]));
    endtask

    // Starts and ends at a negedge with en_i low.
    task automatic step(input int n);
        en_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk_i);
            ne++;
        end
        @(negedge clk_i);
        en_i = 1'b0;
    endtask

    task automatic do_reset();
        en_i = 1'b0;
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        ne = 0;
        for (int c = 0; c < 3; c++) exp_cnt[c] = 0;
    endtask

    task automatic set_mask(input logic [2:0] sel, input logic [7:0] m);
        if (sel[0]) force u0.gen_copy[0].u_chain.upset_mask = m;
        if (sel[1]) force u0.gen_copy[1].u_chain.upset_mask = m;
        if (sel[2]) force u0.gen_copy[2].u_chain.upset_mask = m;
    endtask

    task automatic clr_mask();
        release u0.gen_copy[0].u_chain.upset_mask;
        release u0.gen_copy[1].u_chain.upset_mask;
        release u0.gen_copy[2].u_chain.upset_mask;
    endtask

    // One-edge upset at the head of the copies in sel; ends DEPTH-1 edges later,
    // one edge before the corrupted byte is judged.
    task automatic inject(input logic [2:0] sel, input logic [7:0] m);
        set_mask(sel, m);
        step(1);
        clr_mask();
        step(DEPTH - 1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 vote after reset", 64'(vote_o), 64'h0);
        chk("R9 flags after reset", 64'(mism_o), 64'h0);
        chk("R9 uncorr after reset", 64'(uncorr_o), 64'h0);
        chk_cnts("R9 counters after reset");
    endtask

    task automatic t_fill();
        step(DEPTH);
        chk("R6 vote idle during fill", 64'(vote_o), 64'h0);
        chk("R6 flags idle during fill", 64'(mism_o), 64'h0);
        step(1);
        chk("R1 first voted byte is seed", 64'(vote_o), 64'h01);
    endtask

    task automatic t_stream();
        step(1);
        chk("R1 vote stream", 64'(vote_o), 64'(exp_vote()));
        step(17);
        chk("R1 vote stream", 64'(vote_o), 64'(exp_vote()));
        step(300);
        chk("R1 vote stream after wrap", 64'(vote_o), 64'(exp_vote()));
        chk("R3 no flags in clean run", 64'(mism_o), 64'h0);
        chk_cnts("R4 counters clean run");
    endtask

    task automatic t_single();
        inject(3'b010, 8'h10);
        chk("R3 flag not early", 64'(mism_o), 64'h0);
        step(1);
        exp_cnt[1]++;
        chk("R3 copy1 flagged", 64'(mism_o), 64'b010);
        chk("R2 vote masks single upset", 64'(vote_o), 64'(exp_vote()));
        chk_cnts("R4 copy1 counted once");
        chk("R2 no uncorr on single", 64'(uncorr_o), 64'h0);
        step(1);
        chk("R3 flag clears", 64'(mism_o), 64'h0);
        chk_cnts("R4 counters hold after clear");
    endtask

    task automatic t_two_bits_and_freeze();
        set_mask(3'b001, 8'h01);
        set_mask(3'b100, 8'h80);
        step(1);
        clr_mask();
        step(DEPTH - 1);
        step(1);
        exp_cnt[0]++;
        exp_cnt[2]++;
        chk("R10 both copies flagged", 64'(mism_o), 64'b101);
        chk("R10 vote correct", 64'(vote_o), 64'(exp_vote()));
        chk("R10 no uncorr", 64'(uncorr_o), 64'h0);
        chk_cnts("R10 both counted");
        // Hold en_i low with the flags raised.
        repeat (6) @(negedge clk_i);
        chk("R8 flags frozen", 64'(mism_o), 64'b101);
        chk("R8 vote frozen", 64'(vote_o), 64'(exp_vote()));
        chk_cnts("R8 counters frozen");
        step(1);
        chk("R3 flags clear after resume", 64'(mism_o), 64'h0);
    endtask

    task automatic t_double();
        logic [7:0] good;
        inject(3'b011, 8'h04);
        step(1);
        exp_cnt[2]++;
        good = exp_vote();
        chk("R7 vote corrupted", 64'(vote_o), 64'(good ^ 8'h04));
        chk("R7 uncorr set", 64'(uncorr_o), 64'h1);
        chk("R7 third copy flagged", 64'(mism_o), 64'b100);
        chk_cnts("R7 third copy counted");
        step(25);
        chk("R7 uncorr sticky", 64'(uncorr_o), 64'h1);
        chk("R7 vote clean again", 64'(vote_o), 64'(exp_vote()));
    endtask

    task automatic t_stale();
        int bad = 0;
        // Seed a same-bit double upset, then reset before it drains.
        set_mask(3'b011, 8'h02);
        step(1);
        clr_mask();
        step(3);
        do_reset();
        chk("R9 uncorr cleared", 64'(uncorr_o), 64'h0);
        chk_cnts("R9 counters cleared");
        for (int i = 0; i < DEPTH; i++) begin
            step(1);
            if (mism_o != 3'b000 || uncorr_o || vote_o != 8'h00 || cnt_o != '0) bad++;
        end
        chk("R6 stale data ignored while filling", 64'(bad), 64'h0);
        step(1);
        chk("R1 stream restarts at seed", 64'(vote_o), 64'h01);
        chk("R6 no flag after arming", 64'(mism_o), 64'h0);
    endtask

    task automatic t_sat();
        set_mask(3'b100, 8'h01);
        step(65600);
        chk("R5 counter saturated", 64'(cnt_o[2*CNT_W +: CNT_W]), 64'hFFFF);
        chk("R5 flag still raised", 64'(mism_o), 64'b100);
        chk("R2 vote correct under constant upset", 64'(vote_o), 64'(exp_vote()));
        chk("R5 other counters untouched", 64'(cnt_o[0 +: CNT_W]), 64'h0);
        clr_mask();
    endtask

    initial begin
        @(negedge clk_i);
        t_reset();
        t_fill();
        t_stream();
        t_single();
        t_two_bits_and_freeze();
        t_double();
        t_stale();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_i);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule